// File: doc/BRIEF.md
# Status byte and service request generator

This block builds the 8-bit status byte that an instrument returns to a bus controller. Five summary levels come in from outside: operation, standard event, message available, hardware error and operational error. The block places each one at a fixed bit position without latching it. An 8-bit service request enable mask selects which summaries may raise a request. From these the block derives a live master summary bit, the AND-OR of summaries and enables.

A rising master summary sets a latched request flag, which drives the service request line. The controller has two ways to read the byte.

- The serial poll view carries the latched request in bit 6. A one-cycle poll strobe clears the request and releases the line.
- The status query view carries the live master summary in bit 6 and clears nothing.

All pins are plain control and status levels, so no stream handshake applies. The poll strobe is taken as a single-cycle pulse, and the poll byte is sampled in the cycle in which that pulse is high.

Top module: `srq_status_gen`

## Requirements
- R1: Both read bytes use this layout: bit 7 operation summary, bit 5 standard event summary, bit 4 message available, bit 2 hardware error summary, bit 1 operational error summary. Bits 3 and 0 read 0.
- R2: Summary bits are not latched. A change on a summary input appears in both read bytes in the same cycle, with no clock edge needed.
- R3: The master summary is high when any of bits 7, 5, 4, 2 or 1 is set in both the summary byte and the enable mask. Mask bits 6, 3 and 0 have no effect on it.
- R4: A write strobe loads the enable mask at the clock edge. The mask read returns the written value with bit 6 forced to 0.
- R5: On the edge after the master summary goes from 0 to 1, the request flag and `srq_out` go to 1.
- R6: `poll_byte` bit 6 equals the request flag. A poll strobe clears the flag and `srq_out` at the edge, and leaves the master summary unchanged.
- R7: `stq_byte` bit 6 equals the live master summary, and reading it changes no state.
- R8: While the master summary stays high after a poll, no new request is raised. A later fall followed by a rise raises one again.
- R9: Clearing the relevant enable bit drops the master summary at once. A request that is already latched stays until it is polled.
- R10: If a rise of the master summary arrives in the same cycle as a poll strobe, the request ends up set.
- R11: Reset clears the mask, the request flag and the edge history, so both read bytes and `srq_out` read 0 while all inputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sum_oper | input | 1 | Operation summary level |
| sum_std | input | 1 | Standard event summary level |
| msg_avail | input | 1 | Output buffer holds data |
| sum_hw | input | 1 | Hardware error summary level |
| sum_op | input | 1 | Operational error summary level |
| en_wr | input | 1 | Enable mask write strobe |
| en_wdata | input | 8 | Enable mask write value |
| en_rdata | output | 8 | Enable mask read value, bit 6 always 0 |
| poll_req | input | 1 | Serial poll strobe, one cycle |
| poll_byte | output | 8 | Serial poll response, request flag in bit 6 |
| stq_byte | output | 8 | Status query response, master summary in bit 6 |
| srq_out | output | 1 | Service request line, active high |

## Verification
A vector walk pairs summary patterns with enable masks. It covers a single enabled source, a source set while a different one is enabled, two sources with only one enabled, and every source set under a mask that holds only the ignored bits. Together these separate a correct AND-OR from an OR that skips the mask and from a bit placed in the wrong position.

Directed sequences then exercise the request latch:
- the rise-to-request delay;
- a poll clearing the request while the master summary stays high;
- no repeated request while the master summary stays high;
- a fall followed by a rise;
- a mask clear with a request still latched;
- a rise arriving in the same cycle as a poll.

These separate an edge-triggered request from a level-following one, and separate which of set and clear has priority.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int unsigned STB_W    = 8;
  localparam int unsigned POS_OPER = 7;
  localparam int unsigned POS_REQ  = 6;
  localparam int unsigned POS_STD  = 5;
  localparam int unsigned POS_MAV  = 4;
  localparam int unsigned POS_HW   = 2;
  localparam int unsigned POS_OP   = 1;

  typedef struct packed {
    logic oper;
    logic std;
    logic mav;
    logic hw;
    logic op;
  } summ_t;

  function automatic logic [STB_W-1:0] place_summ(summ_t s);
    logic [STB_W-1:0] b;
    b = '0;
    b[POS_OPER] = s.oper;
    b[POS_STD]  = s.std;
    b[POS_MAV]  = s.mav;
    b[POS_HW]   = s.hw;
    b[POS_OP]   = s.op;
    return b;
  endfunction
endpackage

// File: rtl/srq_enable_reg.sv
module srq_enable_reg
  import srq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [STB_W-1:0] wdata,
  output logic [STB_W-1:0] mask
);
  localparam logic [STB_W-1:0] KEEP = ~(STB_W'(1) << POS_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n)   mask <= '0;
    else if (wr)  mask <= wdata & KEEP;
  end

  a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (mask == ($past(wdata) & KEEP)));
  a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mask));
endmodule

// File: rtl/srq_byte_build.sv
module srq_byte_build
  import srq_pkg::*;
(
  input  summ_t            summ,
  input  logic [STB_W-1:0] mask,
  input  logic             rqs,
  output logic             mss,
  output logic [STB_W-1:0] poll_byte,
  output logic [STB_W-1:0] stq_byte
);
  logic [STB_W-1:0] base;

  always_comb begin
    base = place_summ(summ);
    mss  = |(base & mask);
    poll_byte = base;
    poll_byte[POS_REQ] = rqs;
    stq_byte = base;
    stq_byte[POS_REQ] = mss;
  end
endmodule

// File: rtl/srq_request_latch.sv
module srq_request_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic mss,
  input  logic poll,
  output logic rqs
);
  logic mss_q;
  logic rise;

  assign rise = mss & ~mss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mss_q <= 1'b0;
      rqs   <= 1'b0;
    end else begin
      mss_q <= mss;
      if (rise)      rqs <= 1'b1;
      else if (poll) rqs <= 1'b0;
    end
  end

  a_r5_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mss && !mss_q) |=> rqs);
  a_r6_poll_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (poll && !(mss && !mss_q)) |=> !rqs);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!rqs && !(mss && !mss_q)) |=> !rqs);
endmodule

// File: rtl/srq_status_gen.sv
module srq_status_gen
  import srq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sum_oper,
  input  logic       sum_std,
  input  logic       msg_avail,
  input  logic       sum_hw,
  input  logic       sum_op,
  input  logic       en_wr,
  input  logic [7:0] en_wdata,
  output logic [7:0] en_rdata,
  input  logic       poll_req,
  output logic [7:0] poll_byte,
  output logic [7:0] stq_byte,
  output logic       srq_out
);
  summ_t            summ;
  logic [STB_W-1:0] mask;
  logic             mss;
  logic             rqs;

  assign summ = '{oper: sum_oper, std: sum_std, mav: msg_avail, hw: sum_hw, op: sum_op};

  srq_enable_reg u_en (
    .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(en_wdata), .mask(mask)
  );

  srq_byte_build u_build (
    .summ(summ), .mask(mask), .rqs(rqs),
    .mss(mss), .poll_byte(poll_byte), .stq_byte(stq_byte)
  );

  srq_request_latch u_req (
    .clk(clk), .rst_n(rst_n), .mss(mss), .poll(poll_req), .rqs(rqs)
  );

  assign en_rdata = mask;
  assign srq_out  = rqs;

  a_r3_mss_from_ports: assert property (@(posedge clk) disable iff (!rst_n)
    stq_byte[6] == |(stq_byte & en_rdata & 8'hB6));
  a_r6_poll_bit_is_line: assert property (@(posedge clk) disable iff (!rst_n)
    poll_byte[6] == srq_out);
  a_r1_views_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_byte & 8'hB6) == (stq_byte & 8'hB6) && (stq_byte & 8'h09) == 8'h00);
  a_r7_query_keeps_request: assert property (@(posedge clk) disable iff (!rst_n)
    (srq_out && !poll_req) |=> srq_out);
endmodule

// File: tb/srq_status_gen_tb.sv
module srq_status_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sum_oper = 0, sum_std = 0, msg_avail = 0, sum_hw = 0, sum_op = 0;
  logic en_wr = 0;
  logic [7:0] en_wdata = '0;
  logic [7:0] en_rdata, poll_byte, stq_byte;
  logic poll_req = 0;
  logic srq_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  srq_status_gen u_dut (
    .clk(clk), .rst_n(rst_n), .sum_oper(sum_oper), .sum_std(sum_std),
    .msg_avail(msg_avail), .sum_hw(sum_hw), .sum_op(sum_op),
    .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
    .poll_req(poll_req), .poll_byte(poll_byte), .stq_byte(stq_byte),
    .srq_out(srq_out)
  );

  // {oper,std,mav,hw,op}, mask, expected status query byte
  localparam logic [20:0] VEC [7] = '{
    {5'b00000, 8'hFF, 8'h00},
    {5'b10000, 8'h80, 8'hC0},
    {5'b01000, 8'h80, 8'h20},
    {5'b00100, 8'h10, 8'h50},
    {5'b00011, 8'h02, 8'h46},
    {5'b11111, 8'h49, 8'hB6},
    {5'b00010, 8'h04, 8'h44}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_sum(logic [4:0] s);
    {sum_oper, sum_std, msg_avail, sum_hw, sum_op} = s;
  endtask

  task automatic wr_mask(logic [7:0] m);
    @(negedge clk); en_wr = 1; en_wdata = m;
    @(negedge clk); en_wr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; set_sum(5'b0); poll_req = 0; en_wr = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    #1;
    chk("R11 stq", stq_byte, 8'h00);
    chk("R11 poll", poll_byte, 8'h00);
    chk("R11 mask", en_rdata, 8'h00);
    chk("R11 srq", {7'b0, srq_out}, 8'h00);

    // vector walk: R1, R3, R7
    foreach (VEC[i]) begin
      wr_mask(VEC[i][15:8]);
      set_sum(VEC[i][20:16]);
      #1;
      chk($sformatf("R1/R3/R7 vec%0d", i), stq_byte, VEC[i][7:0]);
      chk($sformatf("R1 poll-view vec%0d", i), poll_byte & 8'hBF, VEC[i][7:0] & 8'hBF);
    end

    // R4 mask read
    wr_mask(8'hFF); #1;
    chk("R4 mask bit6", en_rdata, 8'hBF);

    // R2 unlatched
    do_reset();
    set_sum(5'b01000); #1;
    chk("R2 set", stq_byte, 8'h20);
    set_sum(5'b00000); #1;
    chk("R2 clear", stq_byte, 8'h00);

    // R5 rise sets request
    wr_mask(8'h80);
    set_sum(5'b10000); #1;
    chk("R5 before edge", {7'b0, srq_out}, 8'h00);
    tick(); #1;
    chk("R5 srq", {7'b0, srq_out}, 8'h01);
    chk("R6 poll byte", poll_byte, 8'hC0);
    tick(); #1;
    chk("R7 query keeps", {7'b0, srq_out}, 8'h01);

    // R6 poll clears
    poll_req = 1; tick(); poll_req = 0; #1;
    chk("R6 srq cleared", {7'b0, srq_out}, 8'h00);
    chk("R6 poll byte", poll_byte, 8'h80);
    chk("R6 mss kept", stq_byte, 8'hC0);

    // R8 no re-raise
    tick(); tick(); tick(); #1;
    chk("R8 no reraise", {7'b0, srq_out}, 8'h00);
    set_sum(5'b00000); tick();
    set_sum(5'b10000); tick(); #1;
    chk("R8 reraise", {7'b0, srq_out}, 8'h01);

    // R9 mask clear
    wr_mask(8'h00); #1;
    chk("R9 mss dropped", stq_byte, 8'h80);
    chk("R9 rqs latched", {7'b0, srq_out}, 8'h01);
    poll_req = 1; tick(); poll_req = 0; #1;
    chk("R9 polled", {7'b0, srq_out}, 8'h00);

    // R10 rise with poll
    set_sum(5'b00000); wr_mask(8'h02);
    set_sum(5'b00001); poll_req = 1; tick(); poll_req = 0; #1;
    chk("R10 set wins", {7'b0, srq_out}, 8'h01);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule